// File: doc/BRIEF.md
# Pixel-Mask Port with Hidden Colour-Format Register

This block sits on a byte-wide register bus and serves the palette pixel-mask location. A normal write stores an 8-bit mask, and a normal read returns it. A second register, which selects the packed-pixel colour format, shares the same bus location and has no address of its own.

Software reaches the hidden register with a fixed read sequence. After four back-to-back reads of the mask location, the location is armed. While it is armed, reads return the hidden register and the next write goes to the hidden register. That write also ends the armed state.

The hidden value is decoded into a 2-bit format code for downstream pixel logic. Colour conversion and palette storage are not part of this block.

Top module: `pxfmt_port`

## Requirements
- R1: After reset the mask is 0xFF, the hidden register is 0x00, the format code is 0 and a read of the mask location returns 0xFF.
- R2: A read of the mask location (default address 6) returns the mask when the location is not armed. A write stores the mask when the location is not armed.
- R3: Four consecutive reads of the mask location arm it. The next write to it stores its data in the hidden register and leaves the mask unchanged.
- R4: A write to the mask location after fewer than four reads goes to the mask and restarts the read count from zero.
- R5: Any access to another address clears the read count, whether it is a read or a write. The next write to the mask location then goes to the mask.
- R6: A read while armed returns the hidden register contents and keeps the location armed.
- R7: One write consumes the armed state, so a second write goes to the mask.
- R8: The format code is 1 for hidden value 0xC0 (5:5:5), 2 for 0xC1 (5:6:5) and 3 for 0xC5 (8:8:8, used for both 24- and 32-bit pixels). Every other value gives 0 (8-bit palette).
- R9: Clock cycles with no bus access leave the read count unchanged, so reads separated by idle cycles still count as consecutive.
- R10: A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | Bus access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, combinational from the current state |
| pix_mask | output | 8 | Current pixel mask |
| fmt_code | output | 2 | Decoded colour format: 0 palette, 1 5:5:5, 2 5:6:5, 3 8:8:8 |

## Verification
The unlock is tried with several patterns:
- Exactly four reads followed by a write, which must reach the hidden register.
- Three reads followed by a write, which must reach the mask.
- A four-read run broken by an access to another address, both as a read and as a write.
- A run of reads separated by idle cycles, which must still arm the location.

Extra reads while armed and back-to-back writes distinguish "stays armed until a write" from "arm once". Hidden values 0xC0, 0xC1, 0xC5 and one unlisted value each set the format output. A reset applied while armed confirms that both registers and the sequence are cleared.

// File: rtl/pxfmt_port.sv
module pxfmt_port #(
  parameter int ADDR_W       = 4,
  parameter int MASK_ADDR    = 6,
  parameter int UNLOCK_READS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        acc_rdata,
  output logic [7:0]        pix_mask,
  output logic [1:0]        fmt_code
);
  localparam int CNT_W = $clog2(UNLOCK_READS + 1);
  localparam logic [CNT_W-1:0] CNT_ARM = CNT_W'(UNLOCK_READS);

  logic [7:0]       hidden_q;
  logic [CNT_W-1:0] rd_cnt;
  logic             hit, armed;

  assign hit   = acc_addr == ADDR_W'(MASK_ADDR);
  assign armed = rd_cnt == CNT_ARM;
  assign acc_rdata = !hit ? 8'h00 : (armed ? hidden_q : pix_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_mask <= 8'hFF;
      hidden_q <= 8'h00;
      rd_cnt   <= '0;
    end else if (acc_en) begin
      if (!hit) begin
        rd_cnt <= '0;
      end else if (acc_wr) begin
        if (armed) hidden_q <= acc_wdata;
        else       pix_mask <= acc_wdata;
        rd_cnt <= '0;
      end else if (!armed) begin
        rd_cnt <= rd_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (hidden_q)
      8'hC0:   fmt_code = 2'd1;
      8'hC1:   fmt_code = 2'd2;
      8'hC5:   fmt_code = 2'd3;
      default: fmt_code = 2'd0;
    endcase
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    rd_cnt <= CNT_ARM);

  p_armed_write_keeps_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_wr && hit && armed) |=> $stable(pix_mask));

  p_plain_write_keeps_format_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_wr && hit && !armed) |=> $stable(fmt_code));

  p_other_addr_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !hit) |=> !armed && $stable(pix_mask));

  p_armed_read_stays_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_wr && hit && armed) |=> armed);

  p_write_disarms_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_wr && hit) |=> !armed);

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> $stable(rd_cnt) && $stable(pix_mask));
endmodule

// File: tb/pxfmt_port_bench.sv
module pxfmt_port_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       acc_en, acc_wr;
  logic [3:0] acc_addr;
  logic [7:0] acc_wdata;
  logic [7:0] acc_rdata, pix_mask;
  logic [1:0] fmt_code;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  pxfmt_port u_pxfmt_port (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .pix_mask(pix_mask), .fmt_code(fmt_code)
  );

  // {op, addr, wdata, expected, fmt}; op 0 idle, 1 read, 2 write
  // read: expected = read data; write/idle: expected = mask afterwards
  localparam int N = 40;
  localparam logic [23:0] VEC [N] = '{
    {2'd2,4'd6,8'h3C,8'h3C,2'd0},
    {2'd1,4'd6,8'h00,8'h3C,2'd0}, {2'd1,4'd6,8'h00,8'h3C,2'd0},
    {2'd1,4'd6,8'h00,8'h3C,2'd0}, {2'd1,4'd6,8'h00,8'h3C,2'd0},
    {2'd1,4'd6,8'h00,8'h00,2'd0},
    {2'd2,4'd6,8'hC1,8'h3C,2'd2},
    {2'd2,4'd6,8'h55,8'h55,2'd2},
    {2'd1,4'd6,8'h00,8'h55,2'd2}, {2'd1,4'd6,8'h00,8'h55,2'd2},
    {2'd1,4'd6,8'h00,8'h55,2'd2},
    {2'd2,4'd6,8'hC0,8'hC0,2'd2},
    {2'd1,4'd6,8'h00,8'hC0,2'd2}, {2'd1,4'd6,8'h00,8'hC0,2'd2},
    {2'd1,4'd6,8'h00,8'hC0,2'd2},
    {2'd1,4'd5,8'h00,8'h00,2'd2},
    {2'd1,4'd6,8'h00,8'hC0,2'd2}, {2'd1,4'd6,8'h00,8'hC0,2'd2},
    {2'd1,4'd6,8'h00,8'hC0,2'd2}, {2'd1,4'd6,8'h00,8'hC0,2'd2},
    {2'd1,4'd6,8'h00,8'hC1,2'd2},
    {2'd2,4'd6,8'hC5,8'hC0,2'd3},
    {2'd1,4'd6,8'h00,8'hC0,2'd3}, {2'd1,4'd6,8'h00,8'hC0,2'd3},
    {2'd0,4'd0,8'h00,8'hC0,2'd3},
    {2'd1,4'd6,8'h00,8'hC0,2'd3}, {2'd1,4'd6,8'h00,8'hC0,2'd3},
    {2'd1,4'd6,8'h00,8'hC5,2'd3},
    {2'd2,4'd6,8'h12,8'hC0,2'd0},
    {2'd1,4'd6,8'h00,8'hC0,2'd0}, {2'd1,4'd6,8'h00,8'hC0,2'd0},
    {2'd1,4'd6,8'h00,8'hC0,2'd0}, {2'd1,4'd6,8'h00,8'hC0,2'd0},
    {2'd2,4'd6,8'hC0,8'hC0,2'd1},
    {2'd1,4'd6,8'h00,8'hC0,2'd1}, {2'd1,4'd6,8'h00,8'hC0,2'd1},
    {2'd1,4'd6,8'h00,8'hC0,2'd1}, {2'd1,4'd6,8'h00,8'hC0,2'd1},
    {2'd2,4'd2,8'h77,8'hC0,2'd1},
    {2'd2,4'd6,8'hAA,8'hAA,2'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [3:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
    @(negedge clk);
    acc_en = op != 2'd0; acc_wr = op == 2'd2; acc_addr = a; acc_wdata = d;
    #5 rd = acc_rdata;
    @(posedge clk);
    #1 acc_en = 1'b0;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst = 1'b1; acc_en = 1'b0; acc_wr = 1'b0; acc_addr = 4'd6; acc_wdata = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 mask", pix_mask, 8'hFF);
    check("R1 fmt", fmt_code, 0);
    check("R1 read", acc_rdata, 8'hFF);

    // R2..R10 table walk
    for (int i = 0; i < N; i++) begin
      access(VEC[i][23:22], VEC[i][21:18], VEC[i][17:10], rd);
      if (VEC[i][23:22] == 2'd1) check($sformatf("R2/R6/R10 rd vec%0d", i), rd, VEC[i][9:2]);
      else check($sformatf("R3/R4/R5/R7 mask vec%0d", i), pix_mask, VEC[i][9:2]);
      check($sformatf("R8 fmt vec%0d", i), fmt_code, VEC[i][1:0]);
    end

    // R1: reset while armed clears everything
    for (int k = 0; k < 4; k++) access(2'd1, 4'd6, 8'h00, rd);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check("R1 mask after reset", pix_mask, 8'hFF);
    check("R1 fmt after reset", fmt_code, 0);
    check("R1 read after reset (not armed)", acc_rdata, 8'hFF);
    access(2'd2, 4'd6, 8'h0F, rd);
    check("R1 write after reset goes to mask", pix_mask, 8'h0F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule